// File: doc/BRIEF.md
# Segment Descriptor Cache and Access Checker

This block implements the protected-mode path of a single segment register. When a 16-bit selector is written to it, the block decodes the selector and picks the global or local descriptor table. It reads the 8-byte descriptor in one beat over a synchronous memory port. It then keeps the base, the scaled limit and the access rights in a hidden cache.

After that load, each access request carries an offset and a read/write flag. The block compares the offset with the cached limit, checks the permission and privilege rules, and adds the offset to the cached base. One cycle later it answers with either a linear address or a general-protection fault.

No table is read again until the next selector load. The cached state is visible on three outputs so that an observer can see what the last load put in the cache.

Top module: `seg_desc_unit`

## Requirements
- R1: A load is accepted when `ld_valid` is high and `busy` is low. The block drives `mem_req` high for exactly one cycle, in the cycle after acceptance. `mem_addr` equals the table base plus selector bits 15:3 times 8. Selector bit 2 picks `ltab_base` when 1 and `gtab_base` when 0.
- R2: The memory returns data in the cycle after `mem_req`. The cache outputs change after the next edge, so `busy` is high for two cycles. The descriptor fields are read as follows:
  - `seg_base` is built from byte 7 (bits 31:24) and bytes 4..2 (bits 23:0).
  - The raw 20-bit limit is built from byte 6 bits 3:0 (upper nibble) and bytes 1..0.
  - `seg_rights` is byte 5.
- R3: Byte 6 bit 7 is the granularity bit. When it is 1, the cached limit is the raw limit shifted left 12 bits with the low 12 bits set to ones. When it is 0, the raw limit is zero-extended.
- R4: A null selector is a global-table selector whose index is 0. It issues no memory read and leaves `busy` low. It clears the base, the limit and the rights to 0 one cycle after acceptance. Every later access faults. Local-table index 0 is fetched normally.
- R5: Some loaded descriptors leave the segment unusable and every access faults:
  - rights bit 7 (present) is 0, or
  - rights bit 4 (code/data) is 0.
- R6: For code segments and for expand-up data segments, an offset greater than the cached limit faults. An offset equal to the limit passes.
- R7: A data segment with rights bit 2 set expands downward. Offsets less than or equal to the cached limit fault, and offsets above it pass.
- R8: Rights bit 3 selects code (1) or data (0). Permission is checked as follows:
  - A write to code always faults.
  - A read from code faults when rights bit 1 is 0.
  - A write to data faults when rights bit 1 is 0.
- R9: An access faults when the privilege in bits 1:0 of the loaded selector is numerically greater than the descriptor privilege in rights bits 6:5.
- R10: The response comes one cycle after `acc_valid`. If no rule is violated, `lin_valid` is 1 and `lin_addr` is `seg_base + offset` modulo 2^32. Otherwise `gp_fault` is 1 and `lin_valid` is 0. Both are 0 in cycles that follow no request.
- R11: When a load completes with a usable descriptor, it sets bit 0 (accessed) of the cached rights.
- R12: The cache holds its contents until the next load, and no memory read happens between loads. An access made while `busy` is high faults.
- R13: After reset, the cache outputs are 0, `busy` and `mem_req` are 0, and any access faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load the selector on `ld_sel` |
| ld_sel | input | 16 | Selector to load |
| gtab_base | input | 32 | Byte address of the global descriptor table |
| ltab_base | input | 32 | Byte address of the local descriptor table |
| busy | output | 1 | Descriptor fetch in progress |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rdata | input | 64 | Descriptor data, valid the cycle after `mem_req` |
| acc_valid | input | 1 | Access request |
| acc_wr | input | 1 | Access is a write (1) or read (0) |
| acc_off | input | 32 | Access offset |
| lin_valid | output | 1 | Access passed, `lin_addr` valid |
| lin_addr | output | 32 | Linear address of a passing access |
| gp_fault | output | 1 | Access violated a rule |
| seg_base | output | 32 | Cached base |
| seg_limit | output | 32 | Cached, scaled limit |
| seg_rights | output | 8 | Cached rights byte |

## Verification
The bench probes each limit on both sides of the boundary: `limit`, `limit+1` and `limit-1`. It does this for byte and 4K granularity and for upward and downward expansion. A design with an off-by-one compare or an inverted expand-down test would fault a legal access or pass an illegal one. The bench also checks the null selector against local-table index 0, where a wrong decode would either skip a needed fetch or read a descriptor it must not use. It checks privilege values on either side of the descriptor level and accesses made while a fetch is in progress. It also checks the accessed bit: a cache that forgot the privilege, never set the bit, or served accesses from a half-loaded cache would show wrong responses or rights.

// File: rtl/seg_pkg.sv
package seg_pkg;
  parameter int AW      = 32;
  parameter int SW      = 16;
  parameter int DW      = 64;
  parameter int LW      = 20;
  parameter int GRAN_SH = 12;
  localparam int IDX_W   = SW - 3;
  localparam int DESC_SH = $clog2(DW / 8);

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       mem_seg;
    logic       exec;
    logic       dir_conf;
    logic       rw;
    logic       touched;
  } rights_t;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] lim;
    rights_t       rights;
    logic          usable;
    logic [1:0]    rpl;
  } seg_cache_t;

  function automatic logic [AW-1:0] desc_base(input logic [DW-1:0] d);
    return {d[63:56], d[39:16]};
  endfunction

  function automatic logic [LW-1:0] desc_raw_lim(input logic [DW-1:0] d);
    return {d[51:48], d[15:0]};
  endfunction

  function automatic rights_t desc_rights(input logic [DW-1:0] d);
    return rights_t'(d[47:40]);
  endfunction

  function automatic logic desc_gran(input logic [DW-1:0] d);
    return d[55];
  endfunction

  function automatic logic [AW-1:0] scale_limit(input logic [LW-1:0] l, input logic g);
    return g ? {l, {GRAN_SH{1'b1}}} : AW'(l);
  endfunction

  function automatic logic lim_violation(input logic [AW-1:0] off, input logic [AW-1:0] lim,
                                         input logic down);
    return down ? (off <= lim) : (off > lim);
  endfunction

  function automatic logic perm_violation(input rights_t r, input logic wr);
    if (r.exec) return wr || !r.rw;
    return wr && !r.rw;
  endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
(
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] gtab,
  input  logic [AW-1:0] ltab,
  output logic [AW-1:0] desc_addr,
  output logic          is_null,
  output logic [1:0]    rpl
);
  logic [IDX_W-1:0] idx;
  logic             use_local;

  assign idx       = sel[SW-1:3];
  assign use_local = sel[2];
  assign rpl       = sel[1:0];
  assign is_null   = !use_local && (idx == '0);
  assign desc_addr = (use_local ? ltab : gtab) + (AW'(idx) << DESC_SH);
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic          is_null,
  input  logic [AW-1:0] desc_addr,
  output logic          accept,
  output logic          null_take,
  output logic          cap_en,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fstate_t;
  fstate_t st;

  assign busy      = (st != F_IDLE);
  assign accept    = ld_valid && !busy;
  assign null_take = accept && is_null;
  assign mem_req   = (st == F_REQ);
  assign cap_en    = (st == F_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      mem_addr <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (accept && !is_null) begin
          st       <= F_REQ;
          mem_addr <= desc_addr;
        end
        F_REQ:   st <= F_WAIT;
        default: st <= F_IDLE;
      endcase
    end
  end

  // R1
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_null |=> mem_req);
  // R1
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4
  null_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    null_take |=> !mem_req);
  // R12
  read_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  seg_cache_t    cache,
  input  logic [AW-1:0] off,
  input  logic          wr,
  input  logic          busy,
  output logic          fault,
  output logic [AW-1:0] lin,
  output logic          lim_bad,
  output logic          priv_bad
);
  logic unusable_w;
  logic perm_bad;
  logic down;

  assign down       = !cache.rights.exec && cache.rights.dir_conf;
  assign unusable_w = !cache.usable;
  assign priv_bad   = cache.rpl > cache.rights.dpl;
  assign perm_bad   = perm_violation(cache.rights, wr);
  assign lim_bad    = lim_violation(off, cache.lim, down);
  assign fault      = busy || unusable_w || priv_bad || perm_bad || lim_bad;
  assign lin        = cache.base + off;
endmodule

// File: rtl/seg_desc_unit.sv
module seg_desc_unit
  import seg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [15:0]   ld_sel,
  input  logic [31:0]   gtab_base,
  input  logic [31:0]   ltab_base,
  output logic          busy,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic [63:0]   mem_rdata,
  input  logic          acc_valid,
  input  logic          acc_wr,
  input  logic [31:0]   acc_off,
  output logic          lin_valid,
  output logic [31:0]   lin_addr,
  output logic          gp_fault,
  output logic [31:0]   seg_base,
  output logic [31:0]   seg_limit,
  output logic [7:0]    seg_rights
);
  logic [AW-1:0] desc_addr;
  logic          is_null, accept, null_take, cap_en;
  logic [1:0]    sel_rpl, pend_rpl;
  seg_cache_t    cache;
  rights_t       new_rights;
  logic          desc_live;
  logic          chk_fault, lim_bad, priv_bad;
  logic [AW-1:0] chk_lin;
  logic          unused_desc_bits;

  assign unused_desc_bits = ^mem_rdata[54:52];

  seg_sel_decode u_dec (
    .sel(ld_sel), .gtab(gtab_base), .ltab(ltab_base),
    .desc_addr(desc_addr), .is_null(is_null), .rpl(sel_rpl)
  );

  seg_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .is_null(is_null),
    .desc_addr(desc_addr), .accept(accept), .null_take(null_take),
    .cap_en(cap_en), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  assign new_rights = desc_rights(mem_rdata);
  assign desc_live  = new_rights.present && new_rights.mem_seg;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_rpl <= '0;
    else if (accept)    pend_rpl <= sel_rpl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || null_take) begin
      cache <= '0;
    end else if (cap_en) begin
      cache.base           <= desc_base(mem_rdata);
      cache.lim            <= scale_limit(desc_raw_lim(mem_rdata), desc_gran(mem_rdata));
      cache.rights         <= new_rights;
      cache.rights.touched <= new_rights.touched || desc_live;
      cache.usable         <= desc_live;
      cache.rpl            <= pend_rpl;
    end
  end

  seg_check u_chk (
    .cache(cache), .off(acc_off), .wr(acc_wr), .busy(busy),
    .fault(chk_fault), .lin(chk_lin), .lim_bad(lim_bad), .priv_bad(priv_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_valid <= 1'b0;
      gp_fault  <= 1'b0;
      lin_addr  <= '0;
    end else begin
      lin_valid <= acc_valid && !chk_fault;
      gp_fault  <= acc_valid && chk_fault;
      lin_addr  <= (acc_valid && !chk_fault) ? chk_lin : '0;
    end
  end

  assign seg_base   = cache.base;
  assign seg_limit  = cache.lim;
  assign seg_rights = cache.rights;

  // R10
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lin_valid && gp_fault));
  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (lin_valid || gp_fault));
  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !(lin_valid || gp_fault));
  // R12
  busy_access_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && busy |=> gp_fault);
  // R12
  cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !null_take |=> $stable(seg_base) && $stable(seg_limit) && $stable(seg_rights));
  // R11
  touched_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && desc_live |=> seg_rights[0]);
  // R9
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && priv_bad |=> gp_fault && !lin_valid);
  // R6
  limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && lim_bad |=> gp_fault);
endmodule

// File: tb/tb_seg_desc_unit.sv
module tb_seg_desc_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GT = 32'h0000_1000;
  localparam logic [31:0] LT = 32'h0000_1200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_sel = '0;
  logic        busy, mem_req, lin_valid, gp_fault;
  logic [31:0] mem_addr, lin_addr, seg_base, seg_limit;
  logic [7:0]  seg_rights;
  logic [63:0] mem_rdata = '0;
  logic        acc_valid = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_off = '0;

  logic [63:0] bmem [128];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] e_base, e_lim;
  logic [7:0]  e_rights;
  bit          e_ok;
  logic [1:0]  e_rpl;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_desc_unit dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .gtab_base(GT), .ltab_base(LT), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc_valid(acc_valid),
    .acc_wr(acc_wr), .acc_off(acc_off), .lin_valid(lin_valid),
    .lin_addr(lin_addr), .gp_fault(gp_fault), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_rights(seg_rights)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= bmem[mem_addr[9:3]];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                         input logic [7:0] r, input bit g);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], r, b[23:0], l[15:0]};
  endfunction

  function automatic bit exp_fault(input logic [31:0] off, input bit wr);
    if (!e_ok) return 1;
    if (e_rpl > e_rights[6:5]) return 1;
    if (e_rights[3]) begin
      if (wr || !e_rights[1]) return 1;
      return off > e_lim;
    end
    if (wr && !e_rights[1]) return 1;
    if (e_rights[2]) return !(off > e_lim);
    return off > e_lim;
  endfunction

  task automatic set_model(input logic [15:0] s);
    logic [63:0] d;
    logic [31:0] a, raw;
    a = (s[2] ? LT : GT) + {16'h0, s[15:3], 3'b000};
    if (s[15:3] == 0 && !s[2]) begin
      e_base = 0; e_lim = 0; e_rights = 0; e_ok = 0; e_rpl = 0;
    end else begin
      d = bmem[a[9:3]];
      e_base = {8'h0, d[39:16]} | ({24'h0, d[63:56]} << 24);
      raw = {16'h0, d[15:0]} | ({28'h0, d[51:48]} << 16);
      e_lim = d[55] ? raw * 32'd4096 + 32'd4095 : raw;
      e_rights = d[47:40];
      e_ok = e_rights[7] && e_rights[4];
      if (e_ok) e_rights[0] = 1'b1;
      e_rpl = s[1:0];
    end
  endtask

  task automatic check_cache(input string tag);
    chk(seg_base, e_base, {tag, " R2 base"});
    chk(seg_limit, e_lim, {tag, " R3 limit"});
    chk({24'h0, seg_rights}, {24'h0, e_rights}, {tag, " R11 rights"});
  endtask

  task automatic do_load(input logic [15:0] s);
    logic [31:0] a;
    a = (s[2] ? LT : GT) + {16'h0, s[15:3], 3'b000};
    ld_valid = 1; ld_sel = s;
    @(negedge clk);
    ld_valid = 0;
    if (s[15:3] == 0 && !s[2]) begin
      chk(mem_req, 0, "R4 null no read");
      chk(busy, 0, "R4 null not busy");
    end else begin
      chk(mem_req, 1, "R1 req");
      chk(mem_addr, a, "R1 addr");
      chk(busy, 1, "R2 busy");
      @(negedge clk);
      chk(mem_req, 0, "R1 single beat");
      chk(busy, 1, "R2 busy wait");
      @(negedge clk);
      chk(busy, 0, "R2 done");
    end
    set_model(s);
    check_cache("load");
  endtask

  task automatic do_acc(input logic [31:0] off, input bit wr, input string tag);
    bit f;
    acc_valid = 1; acc_off = off; acc_wr = wr;
    @(negedge clk);
    acc_valid = 0;
    f = exp_fault(off, wr);
    chk(gp_fault, f, {tag, " fault"});
    chk(lin_valid, !f, {tag, " R10 valid"});
    if (!f) chk(lin_addr, e_base + off, {tag, " R10 addr"});
    chk(mem_req, 0, {tag, " R12 no read"});
    @(negedge clk);
    chk(gp_fault | lin_valid, 0, {tag, " R10 idle"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) begin
      logic [7:0] r;
      r = $urandom;
      r[7] = ($urandom % 8) != 0;
      r[4] = ($urandom % 8) != 0;
      r[0] = 1'b0;
      bmem[i] = mk_desc($urandom, $urandom, r, $urandom % 2);
    end
    bmem[1] = mk_desc(32'h1000_0000, 20'h001FF, 8'h92, 0);
    bmem[2] = mk_desc(32'h1000_0000, 20'h001FF, 8'h92, 1);
    bmem[3] = mk_desc(32'h0002_0000, 20'h00FFF, 8'h96, 0);
    bmem[4] = mk_desc(32'h0040_0000, 20'h0FFFF, 8'h9A, 0);
    bmem[5] = mk_desc(32'h0040_0000, 20'h0FFFF, 8'h98, 0);
    bmem[6] = mk_desc(32'h0050_0000, 20'h0FFFF, 8'h90, 0);
    bmem[7] = mk_desc(32'h0060_0000, 20'h0FFFF, 8'hB2, 0);
    bmem[8] = mk_desc(32'h0070_0000, 20'h0FFFF, 8'h12, 0);
    bmem[9] = mk_desc(32'h0070_0000, 20'h0FFFF, 8'h82, 0);
    bmem[64] = mk_desc(32'hABCD_0000, 20'h00100, 8'h92, 0);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(seg_base, 0, "R13 base");
    chk(seg_limit, 0, "R13 limit");
    chk({24'h0, seg_rights}, 0, "R13 rights");
    chk(busy, 0, "R13 busy");
    chk(mem_req, 0, "R13 mem_req");
    e_base = 0; e_lim = 0; e_rights = 0; e_ok = 0; e_rpl = 0;
    do_acc(32'h0, 0, "R13 access");

    // R6 R2 byte granularity example
    do_load(16'h0008);
    chk(seg_limit, 32'h0000_01FF, "R3 g0 limit");
    do_acc(32'h1FF, 0, "R6 at limit");
    chk(lin_addr, 32'h0, "R10 cleared");
    do_acc(32'h200, 1, "R6 past limit");
    // R3 4K granularity
    do_load(16'h0010);
    chk(seg_limit, 32'h001F_FFFF, "R3 g1 limit");
    do_acc(32'h001F_FFFF, 0, "R3 top");
    do_acc(32'h0020_0000, 0, "R3 past");
    // R7 expand-down
    do_load(16'h0018);
    do_acc(32'h0FFF, 0, "R7 at limit");
    do_acc(32'h1000, 1, "R7 above");
    // R8 permissions
    do_load(16'h0020);
    do_acc(32'h10, 0, "R8 code read");
    do_acc(32'h10, 1, "R8 code write");
    do_load(16'h0028);
    do_acc(32'h10, 0, "R8 exec only read");
    do_load(16'h0030);
    do_acc(32'h10, 1, "R8 ro write");
    do_acc(32'h10, 0, "R8 ro read");
    // R9 privilege
    do_load(16'h003A);
    do_acc(32'h10, 0, "R9 rpl above dpl");
    do_load(16'h0039);
    do_acc(32'h10, 0, "R9 rpl equal dpl");
    // R5 unusable
    do_load(16'h0040);
    chk(seg_rights[0], 0, "R11 not set when absent");
    do_acc(32'h10, 0, "R5 not present");
    do_load(16'h0048);
    do_acc(32'h10, 0, "R5 system type");
    // R4 null vs local index 0
    do_load(16'h0003);
    do_acc(32'h0, 0, "R4 null access");
    do_load(16'h0004);
    chk(seg_base, 32'hABCD_0000, "R4 local idx0 fetched");
    do_acc(32'h80, 1, "R4 local idx0 access");
    // R12 access during fetch
    ld_valid = 1; ld_sel = 16'h0008;
    @(negedge clk);
    ld_valid = 0; acc_valid = 1; acc_off = 32'h10; acc_wr = 0;
    @(negedge clk);
    acc_valid = 0;
    chk(gp_fault, 1, "R12 busy access");
    @(negedge clk);
    set_model(16'h0008);
    check_cache("R12 after busy");
    repeat (5) @(negedge clk);
    chk(mem_req, 0, "R12 idle no read");
    check_cache("R12 hold");

    // random
    for (int n = 0; n < 300; n++) begin
      logic [15:0] s;
      s = {$urandom % 32, 3'b000} | ($urandom % 8);
      s[15:8] = 0;
      do_load(s);
      for (int k = 0; k < 6; k++) begin
        logic [31:0] o;
        case ($urandom % 5)
          0: o = e_lim;
          1: o = e_lim + 1;
          2: o = e_lim - 1;
          3: o = $urandom;
          default: o = 0;
        endcase
        do_acc(o, $urandom % 2, "R6 R7 R8 R9 random");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule